// File: doc/BRIEF.md
# Configuration Image Loader with Dual Checksum

The block brings up a calibration datapath from a small byte-wide non-volatile memory. On a start pulse it reads the memory one byte at a time, rebuilds 16-bit words and first checks a fixed signature. It then writes four setup words into internal registers 3 to 6 and checks a header checksum. After that it walks a calibration table of temperature/offset/gain triplets, streaming each entry out, until it finds an end marker whose last slot carries a second checksum.

A single-cycle done pulse closes every run. Four status flags tell the outcome: an unprogrammed memory, a header checksum error, a table checksum error, or a fault because the table was too long or ran past the top of memory. The flags keep their value until the next start. Byte reads go through a request port with a valid/ready handshake. The memory answers each accepted request with one response beat.

Top module: `cfgld_loader`

## Requirements
- R1: A word is built from two byte reads: the low byte at the even address 2w and the high byte at 2w+1.
- R2: If word 0 differs from 0x5449, the run ends with `unprog` set and the other flags clear, and no register write or table entry is issued.
- R3: Words 3, 4, 5 and 6 are written in that order, one `cfg_we` pulse each, with `cfg_idx` equal to the word number (3..6) and `cfg_data` the word.
- R4: Word 7 must equal the bitwise complement of the 16-bit wrapped sum of words 0 to 6. If it does not, `cks1_err` is set, but the register writes from R3 still happen and the table walk continues.
- R5: From word 8 on, triplets (temperature, offset, gain) are emitted in table order, one `ent_valid` pulse per triplet when its gain word arrives. The triplet whose temperature is 0x7FFF is the end marker and is never emitted.
- R6: The gain slot of the end-marker triplet must equal the complement of the 16-bit wrapped sum of all table words before it, including the marker's temperature and offset words. If it does not, `cks2_err` is set.
- R7: If MAX_ENTRIES triplets have been emitted and the next temperature word is not 0x7FFF, the run ends with `fault` set.
- R8: A word that would need a byte address at or above MEM_BYTES is never requested. The run ends with `fault` set instead.
- R9: Each run ends with exactly one single-cycle `done` pulse. `busy` is high from start until done. The flags hold until the next start. A start pulse while busy is ignored.
- R10: A read request keeps `rd_req_valid` and `rd_addr` steady until `rd_req_ready` accepts it. At most one byte read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a load run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_req_valid | output | 1 | Byte read request |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_addr | output | ADDR_W | Byte address of request |
| rd_rsp_valid | input | 1 | Read data beat |
| rd_rsp_data | input | 8 | Read data byte |
| cfg_we | output | 1 | Register write strobe |
| cfg_idx | output | 3 | Target register number (3..6) |
| cfg_data | output | 16 | Register write data |
| ent_valid | output | 1 | Table entry strobe |
| ent_temp | output | 16 | Entry temperature index |
| ent_zero | output | 16 | Entry offset value |
| ent_gain | output | 16 | Entry gain value |
| unprog | output | 1 | Signature mismatch |
| cks1_err | output | 1 | Header checksum mismatch |
| cks2_err | output | 1 | Table checksum mismatch |
| fault | output | 1 | Entry limit or memory top overrun |

## Verification
Some properties are checked on every cycle:
- a request stays stable while it waits for ready,
- `done` lasts one cycle and is followed by idle,
- requests stay inside the memory,
- writes target only registers 3 to 6,
- no marker triplet is streamed,
- an unprogrammed outcome is exclusive.

The checksum arithmetic, the byte order, the ordering of writes and entries, and the limit and overrun faults depend on memory images. Only the bench scenarios can show these, by comparing the streams against a scoreboard built from each image.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   localparam int WORD_W = 16;
   localparam logic [WORD_W-1:0] SIG_DEFAULT = 16'h5449;
   localparam logic [WORD_W-1:0] END_DEFAULT = 16'h7FFF;
   localparam int HDR_SUM_WORDS = 7;   // words 0..6 feed checksum 1
   localparam int CKS1_WORD     = 7;
   localparam int TBL_WORD      = 8;
   localparam int REG_FIRST     = 3;
   localparam int REG_LAST      = 6;

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} seq_state_t;
   typedef enum logic [2:0] {F_IDLE, F_LO_REQ, F_LO_RSP, F_HI_REQ, F_HI_RSP} fetch_state_t;
endpackage

// File: rtl/cfgld_csum.sv
module cfgld_csum #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add,
   input  logic [W-1:0] din,
   output logic [W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum <= '0;
      else if (clr) sum <= '0;
      else if (add) sum <= sum + din;   // wraps to W bits
   end
endmodule

// File: rtl/cfgld_fetch.sv
module cfgld_fetch import cfgld_pkg::*; #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] base,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rsp_valid,
   input  logic [7:0]        rd_rsp_data,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);
   fetch_state_t      st;
   logic [ADDR_W-1:0] base_q;
   logic [7:0]        lo_q;

   assign rd_req_valid = (st == F_LO_REQ) || (st == F_HI_REQ);
   assign rd_addr      = (st == F_HI_REQ) ? base_q + ADDR_W'(1) : base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= F_IDLE;
         base_q   <= '0;
         lo_q     <= '0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         word_vld <= 1'b0;
         unique case (st)
            F_IDLE:   if (go) begin base_q <= base; st <= F_LO_REQ; end
            F_LO_REQ: if (rd_req_ready) st <= F_LO_RSP;
            F_LO_RSP: if (rd_rsp_valid) begin lo_q <= rd_rsp_data; st <= F_HI_REQ; end
            F_HI_REQ: if (rd_req_ready) st <= F_HI_RSP;
            F_HI_RSP: if (rd_rsp_valid) begin
                         word     <= {rd_rsp_data, lo_q};
                         word_vld <= 1'b1;
                         st       <= F_IDLE;
                      end
            default:  st <= F_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq import cfgld_pkg::*; #(
   parameter int               MEM_BYTES   = 4096,
   parameter int               MAX_ENTRIES = 64,
   parameter logic [WORD_W-1:0] SIGNATURE  = SIG_DEFAULT,
   parameter logic [WORD_W-1:0] END_TEMP   = END_DEFAULT,
   localparam int ADDR_W = $clog2(MEM_BYTES),
   localparam int CNT_W  = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              fetch_go,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              word_vld,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] sum1,
   input  logic [WORD_W-1:0] sum2,
   output logic              acc_clr,
   output logic              add1,
   output logic              add2,
   output logic              cfg_we,
   output logic [2:0]        cfg_idx,
   output logic [WORD_W-1:0] cfg_data,
   output logic              ent_valid,
   output logic [WORD_W-1:0] ent_temp,
   output logic [WORD_W-1:0] ent_zero,
   output logic [WORD_W-1:0] ent_gain,
   output logic              busy,
   output logic              done,
   output logic              unprog,
   output logic              cks1_err,
   output logic              cks2_err,
   output logic              fault
);
   localparam logic [ADDR_W-1:0] W_HDR_END = ADDR_W'(HDR_SUM_WORDS);
   localparam logic [ADDR_W-1:0] W_CKS1    = ADDR_W'(CKS1_WORD);
   localparam logic [ADDR_W-1:0] W_TBL     = ADDR_W'(TBL_WORD);
   localparam logic [ADDR_W-1:0] W_REG_LO  = ADDR_W'(REG_FIRST);
   localparam logic [ADDR_W-1:0] W_REG_HI  = ADDR_W'(REG_LAST);
   localparam logic [ADDR_W:0]   TOP       = (ADDR_W+1)'(MEM_BYTES);
   localparam logic [CNT_W-1:0]  ENT_MAX   = CNT_W'(MAX_ENTRIES);

   seq_state_t        state;
   logic [ADDR_W-1:0] widx;
   logic [1:0]        slot;
   logic [CNT_W-1:0]  n_ent;
   logic [WORD_W-1:0] temp_q, zero_q;

   logic [ADDR_W:0] lo_addr;
   logic            past_top, hit, in_tbl, sig_bad, marker_tail, too_many;

   assign lo_addr     = {widx, 1'b0};
   assign past_top    = (lo_addr + (ADDR_W+1)'(1)) >= TOP;
   assign hit         = (state == S_WAIT) && word_vld;
   assign in_tbl      = widx >= W_TBL;
   assign sig_bad     = (widx == '0) && (word != SIGNATURE);
   assign marker_tail = (slot == 2'd2) && (temp_q == END_TEMP);
   assign too_many    = (slot == 2'd0) && (word != END_TEMP) && (n_ent == ENT_MAX);

   assign fetch_go   = (state == S_ISSUE) && !past_top;
   assign fetch_addr = lo_addr[ADDR_W-1:0];
   assign acc_clr    = (state == S_IDLE) && start;
   assign add1       = hit && (widx < W_HDR_END) && !sig_bad;
   assign add2       = hit && in_tbl && !marker_tail && !too_many;

   assign cfg_we   = hit && (widx >= W_REG_LO) && (widx <= W_REG_HI);
   assign cfg_idx  = widx[2:0];
   assign cfg_data = word;

   assign ent_valid = hit && in_tbl && (slot == 2'd2) && (temp_q != END_TEMP);
   assign ent_temp  = temp_q;
   assign ent_zero  = zero_q;
   assign ent_gain  = word;

   assign busy = (state != S_IDLE);
   assign done = (state == S_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         widx     <= '0;
         slot     <= '0;
         n_ent    <= '0;
         temp_q   <= '0;
         zero_q   <= '0;
         unprog   <= 1'b0;
         cks1_err <= 1'b0;
         cks2_err <= 1'b0;
         fault    <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (start) begin
               widx     <= '0;
               slot     <= '0;
               n_ent    <= '0;
               unprog   <= 1'b0;
               cks1_err <= 1'b0;
               cks2_err <= 1'b0;
               fault    <= 1'b0;
               state    <= S_ISSUE;
            end
            S_ISSUE: begin
               if (past_top) begin
                  fault <= 1'b1;
                  state <= S_DONE;
               end else begin
                  state <= S_WAIT;
               end
            end
            S_WAIT: if (word_vld) begin
               widx  <= widx + ADDR_W'(1);
               state <= S_ISSUE;
               if (sig_bad) begin
                  unprog <= 1'b1;
                  state  <= S_DONE;
               end
               if (widx == W_CKS1) cks1_err <= (word != ~sum1);
               if (in_tbl) begin
                  unique case (slot)
                     2'd0: begin
                        if (too_many) begin
                           fault <= 1'b1;
                           state <= S_DONE;
                        end else begin
                           temp_q <= word;
                           slot   <= 2'd1;
                        end
                     end
                     2'd1: begin
                        zero_q <= word;
                        slot   <= 2'd2;
                     end
                     default: begin
                        slot <= 2'd0;
                        if (marker_tail) begin
                           cks2_err <= (word != ~sum2);
                           state    <= S_DONE;
                        end else begin
                           n_ent <= n_ent + CNT_W'(1);
                        end
                     end
                  endcase
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader import cfgld_pkg::*; #(
   parameter int               MEM_BYTES   = 4096,
   parameter int               MAX_ENTRIES = 64,
   parameter logic [WORD_W-1:0] SIGNATURE  = SIG_DEFAULT,
   parameter logic [WORD_W-1:0] END_TEMP   = END_DEFAULT,
   localparam int ADDR_W = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rsp_valid,
   input  logic [7:0]        rd_rsp_data,
   output logic              cfg_we,
   output logic [2:0]        cfg_idx,
   output logic [15:0]       cfg_data,
   output logic              ent_valid,
   output logic [15:0]       ent_temp,
   output logic [15:0]       ent_zero,
   output logic [15:0]       ent_gain,
   output logic              unprog,
   output logic              cks1_err,
   output logic              cks2_err,
   output logic              fault
);
   if (MEM_BYTES < 2 * (TBL_WORD + 3)) begin : g_mem_small
      $error("MEM_BYTES too small to hold header and one triplet");
   end
   if (MEM_BYTES % 2 != 0) begin : g_mem_odd
      $error("MEM_BYTES must be even");
   end
   if (MAX_ENTRIES < 1) begin : g_ent_zero
      $error("MAX_ENTRIES must be at least 1");
   end

   logic              fetch_go, word_vld, acc_clr, add1, add2;
   logic [ADDR_W-1:0] fetch_addr;
   logic [WORD_W-1:0] word, sum1, sum2;

   cfgld_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(fetch_addr),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .word_vld(word_vld), .word(word)
   );

   cfgld_csum #(.W(WORD_W)) u_sum_hdr (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(add1), .din(word), .sum(sum1)
   );

   cfgld_csum #(.W(WORD_W)) u_sum_tbl (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(add2), .din(word), .sum(sum2)
   );

   cfgld_seq #(
      .MEM_BYTES(MEM_BYTES), .MAX_ENTRIES(MAX_ENTRIES),
      .SIGNATURE(SIGNATURE), .END_TEMP(END_TEMP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .fetch_go(fetch_go), .fetch_addr(fetch_addr),
      .word_vld(word_vld), .word(word), .sum1(sum1), .sum2(sum2),
      .acc_clr(acc_clr), .add1(add1), .add2(add2),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .ent_valid(ent_valid), .ent_temp(ent_temp), .ent_zero(ent_zero), .ent_gain(ent_gain),
      .busy(busy), .done(done),
      .unprog(unprog), .cks1_err(cks1_err), .cks2_err(cks2_err), .fault(fault)
   );
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int          MEM_BYTES = 4096,
   parameter logic [15:0] END_TEMP  = 16'h7FFF,
   localparam int ADDR_W = $clog2(MEM_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              rd_req_valid,
   input logic              rd_req_ready,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              cfg_we,
   input logic [2:0]        cfg_idx,
   input logic              ent_valid,
   input logic [15:0]       ent_temp,
   input logic              unprog,
   input logic              cks1_err,
   input logic              cks2_err,
   input logic              fault
);
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R8
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> ({1'b0, rd_addr} < (ADDR_W+1)'(MEM_BYTES)));

   // R3
   wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> (cfg_idx >= 3'd3) && (cfg_idx <= 3'd6));

   // R5
   no_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid |-> ent_temp != END_TEMP);

   // R2
   unprog_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && unprog |-> !cks1_err && !cks2_err && !fault);

   // R9
   out_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we || ent_valid) |-> busy);
endmodule

bind cfgld_loader cfgld_chk #(.MEM_BYTES(MEM_BYTES), .END_TEMP(END_TEMP)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
   .cfg_we(cfg_we), .cfg_idx(cfg_idx), .ent_valid(ent_valid), .ent_temp(ent_temp),
   .unprog(unprog), .cks1_err(cks1_err), .cks2_err(cks2_err), .fault(fault)
);

// File: tb/sim_cfgld_loader.sv
module sim_cfgld_loader;
   localparam int MEM = 44;
   localparam int MAXE = 4;
   localparam int AW = $clog2(MEM);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic busy, done, rd_req_valid, rd_req_ready, rd_rsp_valid;
   logic [AW-1:0] rd_addr;
   logic [7:0] rd_rsp_data;
   logic cfg_we, ent_valid, unprog, cks1_err, cks2_err, fault;
   logic [2:0] cfg_idx;
   logic [15:0] cfg_data, ent_temp, ent_zero, ent_gain;

   always #5 clk = ~clk;

   cfgld_loader #(.MEM_BYTES(MEM), .MAX_ENTRIES(MAXE)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .ent_valid(ent_valid), .ent_temp(ent_temp), .ent_zero(ent_zero), .ent_gain(ent_gain),
      .unprog(unprog), .cks1_err(cks1_err), .cks2_err(cks2_err), .fault(fault)
   );

   int n_chk = 0, n_bad = 0, done_cnt = 0, bad_addr = 0;
   logic [7:0] mem [0:MEM-1];
   logic [18:0] exp_wr[$];
   logic [47:0] exp_ent[$];
   logic [15:0] cfg_vals [0:3];
   logic [4:0] lfsr = 5'h1B;

   task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: one response beat, a cycle after acceptance; ready wobbles
   assign rd_req_ready = lfsr[0] | lfsr[3];
   always @(posedge clk) begin
      lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      rd_rsp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
         rd_rsp_valid <= 1'b1;
         if (int'(rd_addr) < MEM) rd_rsp_data <= mem[rd_addr];
         else begin rd_rsp_data <= 8'hXX; bad_addr++; end
      end
   end

   // monitor: pops scoreboard on each design output event
   always @(negedge clk) if (rst_n) begin
      if (done) done_cnt++;
      if (cfg_we) begin
         if (exp_wr.size() == 0) chk("R3 unexpected write", {29'd0, cfg_idx, cfg_data}, 48'hDEAD);
         else chk("R3/R1 register write", {29'd0, cfg_idx, cfg_data}, {29'd0, exp_wr.pop_front()});
      end
      if (ent_valid) begin
         if (exp_ent.size() == 0) chk("R5 unexpected entry", {ent_temp, ent_zero, ent_gain}, 48'hDEAD);
         else chk("R5 table entry", {ent_temp, ent_zero, ent_gain}, exp_ent.pop_front());
      end
   end

   task automatic put(int w, logic [15:0] v);
      if (2 * w + 1 < MEM) begin
         mem[2*w]   = v[7:0];
         mem[2*w+1] = v[15:8];
      end
   endtask

   // tail: 0 marker with checksum, 1 extra non-marker temperature, 2 marker cut by memory top
   task automatic build(logic [15:0] sig, bit bad1, int nent, int tail, bit bad2);
      logic [15:0] s;
      for (int i = 0; i < MEM; i++) mem[i] = 8'hA5;
      put(0, sig); put(1, 16'h0); put(2, 16'h0);
      s = sig;
      for (int i = 0; i < 4; i++) begin
         put(3 + i, cfg_vals[i]);
         s = s + cfg_vals[i];
         if (sig == 16'h5449) exp_wr.push_back({3'(3 + i), cfg_vals[i]});
      end
      put(7, ~s ^ {15'd0, bad1});
      s = 16'h0;
      for (int k = 0; k < nent; k++) begin
         logic [15:0] t, z, g;
         t = 16'h0100 * 16'(k + 1) + 16'h0012;
         z = 16'h0640 + 16'(k * 3);
         g = 16'hF0E1 - 16'(k) * 16'h0111;
         put(8 + 3*k, t); put(9 + 3*k, z); put(10 + 3*k, g);
         s = s + t + z + g;
         if (sig == 16'h5449) exp_ent.push_back({t, z, g});
      end
      case (tail)
         0: begin
            put(8 + 3*nent, 16'h7FFF); put(9 + 3*nent, 16'h0000);
            put(10 + 3*nent, ~(s + 16'h7FFF) ^ {15'd0, bad2});
         end
         1: put(8 + 3*nent, 16'h0123);
         default: begin put(8 + 3*nent, 16'h7FFF); put(9 + 3*nent, 16'h0000); end
      endcase
   endtask

   // flags packed {unprog, cks1_err, cks2_err, fault}
   task automatic run(string req, logic [3:0] exp_flags, bit restart);
      int cyc = 0;
      done_cnt = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R9 busy after start", 48'(busy), 48'd1);
      while (!done && cyc < 3000) begin
         @(negedge clk); cyc++;
         if (restart && cyc == 12) start = 1'b1;
         if (restart && cyc == 13) start = 1'b0;
      end
      if (!done) chk({req, " watchdog"}, 48'd0, 48'd1);
      chk({req, " flags at done"}, 48'({unprog, cks1_err, cks2_err, fault}), 48'(exp_flags));
      repeat (4) @(negedge clk);
      chk("R9 flags hold", 48'({unprog, cks1_err, cks2_err, fault}), 48'(exp_flags));
      chk("R9 single done", 48'(done_cnt), 48'd1);
      chk("R3 writes all seen", 48'(exp_wr.size()), 48'd0);
      chk("R5 entries all seen", 48'(exp_ent.size()), 48'd0);
      exp_wr.delete(); exp_ent.delete();
   endtask

   initial begin
      cfg_vals[0] = 16'h0500; cfg_vals[1] = 16'h1611;
      cfg_vals[2] = 16'h0A47; cfg_vals[3] = 16'h1603;
      repeat (3) @(negedge clk);
      chk("reset busy", 48'(busy), 48'd0);
      chk("reset done/req", 48'({done, rd_req_valid, cfg_we, ent_valid}), 48'd0);
      chk("reset flags", 48'({unprog, cks1_err, cks2_err, fault}), 48'd0);
      rst_n = 1'b1;
      // R4 R6: clean image, one entry
      build(16'h5449, 0, 1, 0, 0); run("R4 R6 clean one entry", 4'b0000, 0);
      // R6: empty table, marker only
      build(16'h5449, 0, 0, 0, 0); run("R6 empty table", 4'b0000, 0);
      // R2: wrong signature
      build(16'h5448, 0, 2, 0, 0); run("R2 unprogrammed", 4'b1000, 0);
      // R4: header checksum wrong, writes still applied
      cfg_vals[0] = 16'h3C5A; cfg_vals[1] = 16'h8001;
      build(16'h5449, 1, 2, 0, 0); run("R4 header checksum error", 4'b0100, 0);
      // R6: table checksum wrong
      build(16'h5449, 0, 3, 0, 1); run("R6 table checksum error", 4'b0010, 0);
      // R7: entry limit
      build(16'h5449, 0, 4, 1, 0); run("R7 entry limit", 4'b0001, 0);
      // R8: marker gain slot beyond memory top
      build(16'h5449, 0, 4, 2, 0); run("R8 memory top", 4'b0001, 0);
      // R9: start while busy ignored
      build(16'h5449, 0, 3, 0, 0); run("R9 restart ignored", 4'b0000, 1);
      chk("R8 R10 no out-of-range read", 48'(bad_addr), 48'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule